// File: doc/BRIEF.md
# Two-Phase Serial Register Port

This block is the slave side of a serial control port that fronts a bank of twelve configuration registers of unequal length. A host opens a communication cycle by pulling the active-low select low. It then clocks in one command byte, followed by as many data bytes as the addressed register holds. A write lands in a shadow copy of the register. A single-cycle update strobe copies every shadow register into the active copy, and the active copy is what the consuming logic sees. A read returns the shadow contents. Read data comes out either on the shared data line, with an enable for the pad, or on a separate output line, depending on a wiring-mode input.

All port inputs are assumed to be already synchronous to the system clock `clk`. The serial clock is oversampled, and its rising and falling transitions are detected as one-cycle events. The control FSM has three states. ST_IDLE covers deselect or abort: counters are cleared and outputs are released. ST_INSTR collects the command byte. ST_DATA moves the data bytes. The transitions are:
- idle-to-command when select is low and the abort line is low;
- command-to-data on the eighth rising serial edge;
- data-to-command on the last rising edge of the last byte;
- any-to-idle whenever select goes high or the abort line is high.

Active register `a` appears on `active_bus[48*a +: 48]`. A register of n bytes occupies the low 8n bits of its slot, and the bits above stay zero.

Top module: `ser_reg_port`

## Requirements
- R1: The command byte arrives MSB first. Its bit 7 set means read and clear means write. Bits 3:0 give the register address, and bits 6:4 have no effect.
- R2: The data phase length is set by the address: 2 bytes for addresses 0, 1, 8, 9 and 11; 6 bytes for 2, 3 and 4; 4 bytes for 5 and 7; 3 bytes for 6; 1 byte for 10 and for every address of 12 or more.
- R3: Write data is taken on rising serial edges, MSB first within a byte, with the most significant byte of the register first. A completed byte goes into the shadow copy, and the active copy does not change.
- R4: A one-cycle `update` pulse copies all twelve shadow registers into `active_bus` on the next clock edge. Without the pulse, `active_bus` holds its value.
- R5: With `mode_4wire` low, a read drives the shadow bytes on `sdio_out` with `sdio_oe` high. Each bit is launched on a falling serial edge, most significant byte and bit first.
- R6: With `mode_4wire` high, read data goes out on `sdo_out` with `sdo_oe` high, and `sdio_oe` stays low. The two enables are never high together.
- R7: After the last data byte, the next eight rising serial edges form a new command byte without any change on `cs_n`.
- R8: A high `io_reset` ends the cycle at once. A partly shifted byte is discarded, and bytes already completed remain. After `io_reset` falls, the next eight rising edges form a command byte.
- R9: While `cs_n` is high, both output enables are low, serial edges are ignored, and a later selection starts with a command byte.
- R10: Addresses 12 to 15 consume one data byte with no register effect, and a read of them returns zero.
- R11: After `rst_n`, all shadow and active registers are zero and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| io_reset | input | 1 | Active-high cycle abort |
| sdio_in | input | 1 | Serial data in from the shared data pin |
| mode_4wire | input | 1 | 1: read data on sdo_out; 0: read data on the shared pin |
| update | input | 1 | One-cycle shadow-to-active transfer strobe |
| sdio_out | output | 1 | Read data for the shared pin |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| sdo_out | output | 1 | Read data for the dedicated output pin |
| sdo_oe | output | 1 | Drive enable for the dedicated output pin |
| active_bus | output | 576 | Active register copies, 48 bits per address |

## Verification
The hardest situation to reach is a mismatch between the byte count the port expects and the byte count the host sends. From outside, this shows only as a misparsed command later on. The stimulus therefore chains a write and a read-back of every address inside a single selection. An extra or missing data byte would turn the read's command byte into data and corrupt the value returned. The same chaining follows an abort in the middle of a byte and a write to an unused address, so the realignment after each shows up in the data that comes back.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INSTR,
        ST_DATA
    } port_state_t;

    // Data-phase byte count for each register address.
    function automatic logic [2:0] reg_len(input logic [3:0] a);
        unique case (a)
            4'd2, 4'd3, 4'd4: reg_len = 3'd6;
            4'd5, 4'd7:       reg_len = 3'd4;
            4'd6:             reg_len = 3'd3;
            4'd0, 4'd1, 4'd8,
            4'd9, 4'd11:      reg_len = 3'd2;
            default:          reg_len = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/ser_edge_det.sv
module ser_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank #(
    parameter int NREG   = 12,
    parameter int NBYTES = 6,
    localparam int SLOTW = NBYTES * 8,
    localparam int BUSW  = NREG * SLOTW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [3:0]      wr_addr,
    input  logic [2:0]      wr_idx,
    input  logic [7:0]      wr_byte,
    input  logic            update,
    input  logic [3:0]      rd_addr,
    input  logic [2:0]      rd_idx,
    output logic [7:0]      rd_byte,
    output logic [BUSW-1:0] shadow_flat,
    output logic [BUSW-1:0] active_flat
);
    logic [SLOTW-1:0] shadow_q [NREG];
    logic [SLOTW-1:0] active_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[g] <= '0;
            end else if (wr_en && wr_addr == 4'(g)) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (wr_idx == 3'(b)) shadow_q[g][b*8 +: 8] <= wr_byte;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      active_q[g] <= '0;
            else if (update) active_q[g] <= shadow_q[g];
        end

        assign shadow_flat[g*SLOTW +: SLOTW] = shadow_q[g];
        assign active_flat[g*SLOTW +: SLOTW] = active_q[g];
    end

    always_comb begin
        rd_byte = '0;
        for (int r = 0; r < NREG; r++) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (rd_addr == 4'(r) && rd_idx == 3'(b)) rd_byte = shadow_q[r][b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import ser_reg_pkg::*;
#(
    parameter int NREG      = 12,
    parameter int MAX_BYTES = 6,
    localparam int SLOTW    = MAX_BYTES * 8,
    localparam int BUSW     = NREG * SLOTW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            io_reset,
    input  logic            sdio_in,
    input  logic            mode_4wire,
    input  logic            update,
    output logic            sdio_out,
    output logic            sdio_oe,
    output logic            sdo_out,
    output logic            sdo_oe,
    output logic [BUSW-1:0] active_bus
);
    port_state_t state_q, state_d;
    logic        rise, fall, abort;
    logic [2:0]  bit_q, byte_q, len_q, cur_idx;
    logic [6:0]  instr_sh, din_sh;
    logic        rd_q, out_q, drive, wr_en, last_bit;
    logic [3:0]  addr_q;
    logic [7:0]  rd_byte;
    logic [BUSW-1:0] shadow_flat;

    ser_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    assign abort    = cs_n | io_reset;
    assign last_bit = rise && bit_q == 3'd7;
    assign cur_idx  = len_q - 3'd1 - byte_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!abort) state_d = ST_INSTR;
            ST_INSTR: begin
                if (abort)         state_d = ST_IDLE;
                else if (last_bit) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (abort)                                   state_d = ST_IDLE;
                else if (last_bit && byte_q == len_q - 3'd1) state_d = ST_INSTR;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Bit/byte counters and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= '0;
            byte_q   <= '0;
            len_q    <= 3'd1;
            instr_sh <= '0;
            din_sh   <= '0;
            rd_q     <= 1'b0;
            addr_q   <= '0;
        end else if (state_q == ST_IDLE || abort) begin
            bit_q  <= '0;
            byte_q <= '0;
        end else if (rise) begin
            bit_q <= bit_q + 3'd1;
            if (state_q == ST_INSTR) begin
                instr_sh <= {instr_sh[5:0], sdio_in};
                if (bit_q == 3'd7) begin
                    rd_q   <= instr_sh[6];
                    addr_q <= {instr_sh[2:0], sdio_in};
                    len_q  <= reg_len({instr_sh[2:0], sdio_in});
                    byte_q <= '0;
                end
            end else begin
                din_sh <= {din_sh[5:0], sdio_in};
                if (bit_q == 3'd7)
                    byte_q <= (byte_q == len_q - 3'd1) ? 3'd0 : byte_q + 3'd1;
            end
        end
    end

    assign wr_en = last_bit && !abort && state_q == ST_DATA && !rd_q;

    ser_reg_bank #(.NREG(NREG), .NBYTES(MAX_BYTES)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (addr_q),
        .wr_idx     (cur_idx),
        .wr_byte    ({din_sh, sdio_in}),
        .update     (update),
        .rd_addr    (addr_q),
        .rd_idx     (cur_idx),
        .rd_byte    (rd_byte),
        .shadow_flat(shadow_flat),
        .active_flat(active_bus)
    );

    // Output bit, launched on the falling serial edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   out_q <= 1'b0;
        else if (fall && state_q == ST_DATA && rd_q)  out_q <= rd_byte[~bit_q];
    end

    assign drive    = state_q == ST_DATA && rd_q && !abort;
    assign sdio_oe  = drive && !mode_4wire;
    assign sdo_oe   = drive && mode_4wire;
    assign sdio_out = sdio_oe & out_q;
    assign sdo_out  = sdo_oe & out_q;
endmodule

// File: rtl/ser_reg_port_chk.sv
module ser_reg_port_chk
    import ser_reg_pkg::*;
#(
    parameter int BUSW = 576
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            io_reset,
    input logic            mode_4wire,
    input logic            update,
    input logic            sdio_oe,
    input logic            sdo_oe,
    input logic [BUSW-1:0] active_bus,
    input logic [BUSW-1:0] shadow_flat,
    input port_state_t     state_q,
    input logic [2:0]      byte_q,
    input logic [2:0]      len_q
);
    assert_update_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> active_bus == $past(shadow_flat));

    assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(active_bus));

    assert_enables_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));

    assert_four_wire_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_4wire |-> !sdio_oe);

    assert_byte_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DATA |-> byte_q < len_q);

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_reset |=> state_q == ST_IDLE);

    assert_deselect_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdio_oe && !sdo_oe);
endmodule

bind ser_reg_port ser_reg_port_chk #(.BUSW(BUSW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .io_reset   (io_reset),
    .mode_4wire (mode_4wire),
    .update     (update),
    .sdio_oe    (sdio_oe),
    .sdo_oe     (sdo_oe),
    .active_bus (active_bus),
    .shadow_flat(shadow_flat),
    .state_q    (state_q),
    .byte_q     (byte_q),
    .len_q      (len_q)
);

// File: tb/sim_ser_reg_port.sv
module sim_ser_reg_port;
    localparam int NREG = 12;
    localparam int BUSW = NREG * 48;

    localparam logic [47:0] VEC_DATA [0:11] = '{
        48'h00000000A51C, 48'h000000003C96, 48'h0123456789AB, 48'hFEDCBA987654,
        48'h5A5AC3C30F0F, 48'h0000CAFE0123, 48'h00000013579B, 48'h00002468ACE0,
        48'h000000008001, 48'h000000007FFE, 48'h0000000000C7, 48'h000000000F3C
    };
    localparam int VEC_LEN [0:11] = '{2, 2, 6, 6, 6, 4, 3, 4, 2, 2, 1, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, io_reset = 1'b0, sdio_in = 1'b0;
    logic mode_4wire = 1'b0, update = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [BUSW-1:0] active_bus;

    int checks = 0;
    int fails  = 0;
    bit oe_bad;

    always #2 clk = ~clk;

    ser_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .io_reset(io_reset),
        .sdio_in(sdio_in), .mode_4wire(mode_4wire), .update(update),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .active_bus(active_bus)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One serial bit; exp_drive tells whether read data should be driven.
    task automatic sbit(input logic tx, output logic rx, input bit exp_drive);
        sclk = 1'b0;
        sdio_in = tx;
        tick(3);
        rx = mode_4wire ? sdo_out : sdio_out;
        if (sdio_oe !== (exp_drive && !mode_4wire) || sdo_oe !== (exp_drive && mode_4wire))
            oe_bad = 1'b1;
        tick(1);
        sclk = 1'b1;
        tick(4);
    endtask

    task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx, input bit exp_drive);
        for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i], exp_drive);
    endtask

    task automatic wr_reg(input logic [3:0] addr, input logic [2:0] ign,
                          input int len, input logic [47:0] data);
        logic [7:0] rx;
        sbyte({1'b0, ign, addr}, rx, 1'b0);
        for (int k = 0; k < len; k++) sbyte(data[8*(len-1-k) +: 8], rx, 1'b0);
    endtask

    task automatic rd_reg(input logic [3:0] addr, input int len, output logic [47:0] data);
        logic [7:0] rx;
        sbyte({1'b1, 3'b000, addr}, rx, 1'b0);
        data = '0;
        for (int k = 0; k < len; k++) begin
            sbyte(8'h00, rx, 1'b1);
            data = {data[39:0], rx};
        end
    endtask

    task automatic select;
        cs_n = 1'b0;
        tick(2);
    endtask

    task automatic deselect;
        tick(2);
        cs_n = 1'b1;
        sclk = 1'b1;
        tick(2);
    endtask

    task automatic pulse_update;
        update = 1'b1;
        tick(1);
        update = 1'b0;
        tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] got;
        logic rx1;
        logic [7:0] rx8;

        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R11: reset state
        chk("R11 enables", {62'd0, sdio_oe, sdo_oe}, 64'd0);
        chk("R11 active", {63'd0, |active_bus}, 64'd0);

        // Table walk: write then read back in the same selection (R1 R2 R3 R5 R7), then update (R4)
        for (int i = 0; i < NREG; i++) begin
            oe_bad = 1'b0;
            select();
            wr_reg(4'(i), 3'b101, VEC_LEN[i], VEC_DATA[i]);
            rd_reg(4'(i), VEC_LEN[i], got);
            deselect();
            chk($sformatf("R2 R5 R7 readback addr %0d", i), {16'd0, got}, {16'd0, VEC_DATA[i]});
            chk($sformatf("R5 enable addr %0d", i), {63'd0, oe_bad}, 64'd0);
            chk($sformatf("R3 active held addr %0d", i), {16'd0, active_bus[48*i +: 48]}, 64'd0);
            pulse_update();
            chk($sformatf("R4 active addr %0d", i), {16'd0, active_bus[48*i +: 48]},
                {16'd0, VEC_DATA[i]});
        end

        // R6: dedicated output wiring
        mode_4wire = 1'b1;
        oe_bad = 1'b0;
        select();
        rd_reg(4'd2, 6, got);
        deselect();
        chk("R6 sdo data", {16'd0, got}, {16'd0, VEC_DATA[2]});
        chk("R6 enables", {63'd0, oe_bad}, 64'd0);
        mode_4wire = 1'b0;

        // R8: abort mid-byte, first byte already complete
        select();
        sbyte(8'h00, rx8, 1'b0);
        sbyte(8'hAA, rx8, 1'b0);
        for (int b = 0; b < 3; b++) sbit(1'b1, rx1, 1'b0);
        io_reset = 1'b1;
        tick(3);
        io_reset = 1'b0;
        tick(2);
        rd_reg(4'd0, 2, got);
        deselect();
        chk("R8 realign after abort", {16'd0, got}, 64'h000000000000AA1C);

        // R9: deselect mid-read and mid-write, edges while deselected ignored
        select();
        sbyte(8'h89, rx8, 1'b0);
        for (int b = 0; b < 3; b++) sbit(1'b0, rx1, 1'b1);
        cs_n = 1'b1;
        tick(1);
        chk("R9 enables released", {62'd0, sdio_oe, sdo_oe}, 64'd0);
        sbyte(8'h0A, rx8, 1'b0);
        sbyte(8'h55, rx8, 1'b0);
        select();
        sbyte(8'h0A, rx8, 1'b0);
        for (int b = 0; b < 4; b++) sbit(1'b0, rx1, 1'b0);
        deselect();
        select();
        rd_reg(4'd10, 1, got);
        deselect();
        chk("R9 addr 10 untouched", {16'd0, got}, 64'h00000000000000C7);

        // R10: unused addresses consume one byte, read zero
        select();
        wr_reg(4'd12, 3'b000, 1, 48'hFF);
        rd_reg(4'd13, 1, got);
        chk("R10 unused reads zero", {16'd0, got}, 64'd0);
        rd_reg(4'd11, 2, got);
        deselect();
        chk("R10 R2 alignment kept", {16'd0, got}, {16'd0, VEC_DATA[11]});

        // R1: ignored bits 6:4 set on a read command
        select();
        sbyte(8'hF8, rx8, 1'b0);
        got = '0;
        for (int k = 0; k < 2; k++) begin
            sbyte(8'h00, rx8, 1'b1);
            got = {got[39:0], rx8};
        end
        deselect();
        chk("R1 ignored bits on read", {16'd0, got}, {16'd0, VEC_DATA[8]});

        // R4: no update means no change after new shadow writes
        select();
        wr_reg(4'd9, 3'b000, 2, 48'h1234);
        deselect();
        tick(4);
        chk("R4 hold without update", {16'd0, active_bus[48*9 +: 48]}, {16'd0, VEC_DATA[9]});
        pulse_update();
        chk("R4 update after write", {16'd0, active_bus[48*9 +: 48]}, 64'h1234);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule